// File: doc/BRIEF.md
# Rotate-and-Fill Bitfield Shift Unit

This unit computes every shift-class result of a 32-bit integer datapath in one shared path. The supported results are logical and arithmetic shifts, rotates, byte and halfword sign extension, halfword zero extension, unsigned and signed bitfield extraction, and single-bit set, clear, invert and test. Each operation is reduced to three things: a left-rotate amount, a per-bit keep mask and a fill bit. The final value keeps the rotated data where the mask is set and places the fill bit everywhere else.

The rotate is built from two half-width multiplications. Each operand half is multiplied by a one-hot power of two taken from the low count bits. The two products are folded into one rotated word. The top count bit then chooses between that word and its half-swapped copy. While the multiplications run, three other pieces work in parallel: a mux that picks the source bit for the fill, a zero/one/pass/invert stage on that bit, and the mask generator.

The result is registered. The caller presents the operation, operand, count and width on one clock edge and reads the result after the next edge.

Top module: `bfx_unit`

## Requirements
- R1: Operation code 0 (shift left) returns the operand shifted left by the count, with zeros in the vacated low bits.
- R2: Operation code 1 (logical right) returns the operand shifted right by the count, with zeros in the vacated high bits.
- R3: Operation code 2 (arithmetic right) returns the operand shifted right by the count, with the high bits filled from operand bit 31.
- R4: Operation code 3 rotates the operand left by the count. Operation code 4 rotates it right by the count. In both, no bit is lost.
- R5: Operation code 5 sign-extends operand bits 7:0. Code 6 sign-extends bits 15:0. Code 7 zero-extends bits 15:0. The count and width inputs have no effect on these three.
- R6: Operation code 8 (unsigned extract) rotates the operand right by the count, keeps the low (width input + 1) bits and zeroes the rest.
- R7: Operation code 9 (signed extract) keeps the same low bits as R6, and fills the rest with bit (width input) of the rotated value.
- R8: Operation codes 10, 11 and 12 set, clear and invert operand bit (count) respectively. Every other bit is left unchanged.
- R9: Operation code 13 returns operand bit (count) in result bit 0, with all other bits zero.
- R10: The result appears on the output one clock edge after the inputs are sampled. While reset (active low) is asserted, the output is zero.
- R11: Operation codes 14 and 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (see requirements) |
| opa_i | input | 32 | Operand |
| cnt_i | input | 5 | Shift count, field position or bit index |
| wid_i | input | 5 | Field width minus one, used by extract operations |
| res_o | output | 32 | Registered result |

## Verification
Every result is due exactly one rising edge after its inputs are captured, whatever the operation. The bench therefore changes inputs on a falling edge and compares the output on the following falling edge, half a period after the capturing edge and before the next input change. The reset value is read while reset is held. The in-RTL properties use a flag that is set only after the first edge out of reset, so that each one-cycle-back reference points at inputs that were really captured.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
   typedef enum logic [3:0] {
      OP_SLL   = 4'd0,
      OP_SRL   = 4'd1,
      OP_SRA   = 4'd2,
      OP_ROL   = 4'd3,
      OP_ROR   = 4'd4,
      OP_SEXTB = 4'd5,
      OP_SEXTH = 4'd6,
      OP_ZEXTH = 4'd7,
      OP_EXTU  = 4'd8,
      OP_EXTS  = 4'd9,
      OP_BSET  = 4'd10,
      OP_BCLR  = 4'd11,
      OP_BINV  = 4'd12,
      OP_BEXT  = 4'd13
   } op_e;

   typedef enum logic [1:0] {
      FILL_ZERO = 2'd0,
      FILL_ONE  = 2'd1,
      FILL_PASS = 2'd2,
      FILL_INV  = 2'd3
   } fill_e;
endpackage

// File: rtl/bfx_halfmul.sv
// One half-width lane: the data is multiplied by 2^n, which moves it left by n
// into a double-width product.
module bfx_halfmul #(
   parameter int HALF = 16,
   localparam int NW = $clog2(HALF)
) (
   input  logic [HALF-1:0]   d_i,
   input  logic [NW-1:0]     n_i,
   output logic [2*HALF-1:0] p_o
);
   logic [2*HALF-1:0] factor;
   logic [2*HALF-1:0] dext;

   always_comb begin
      factor = (2*HALF)'(1) << n_i;
      dext   = {{HALF{1'b0}}, d_i};
      p_o    = dext * factor;
   end
endmodule

// File: rtl/bfx_ctrl.sv
// Decode: turns an operation into a left-rotate amount, a keep mask, the index
// of the fill source bit and the fill function.
module bfx_ctrl
   import bfx_pkg::*;
#(
   parameter int XLEN = 32,
   localparam int CW = $clog2(XLEN)
) (
   input  logic [3:0]      op_i,
   input  logic [CW-1:0]   cnt_i,
   input  logic [CW-1:0]   wid_i,
   output logic [CW-1:0]   rotl_o,
   output logic [XLEN-1:0] keep_o,
   output logic [CW-1:0]   fidx_o,
   output fill_e           ffn_o
);
   localparam logic [CW:0] FULL = (CW+1)'(XLEN);

   function automatic logic [XLEN-1:0] lowmask(input logic [CW:0] k);
      return ~({XLEN{1'b1}} << k);
   endfunction

   logic [CW-1:0] negcnt;
   logic [CW:0]   cntx;
   logic [CW:0]   widx;
   logic [CW-1:0] top_idx;
   logic [XLEN-1:0] bit_hot;

   always_comb begin
      negcnt  = CW'(0) - cnt_i;
      cntx    = {1'b0, cnt_i};
      widx    = {1'b0, wid_i} + (CW+1)'(1);
      top_idx = cnt_i + wid_i;
      bit_hot = XLEN'(1) << cnt_i;

      rotl_o = '0;
      keep_o = '0;
      fidx_o = '0;
      ffn_o  = FILL_ZERO;
      case (op_e'(op_i))
         OP_SLL:   begin rotl_o = cnt_i;  keep_o = ~lowmask(cntx); end
         OP_SRL:   begin rotl_o = negcnt; keep_o = lowmask(FULL - cntx); end
         OP_SRA:   begin rotl_o = negcnt; keep_o = lowmask(FULL - cntx);
                         fidx_o = CW'(XLEN-1); ffn_o = FILL_PASS; end
         OP_ROL:   begin rotl_o = cnt_i;  keep_o = '1; end
         OP_ROR:   begin rotl_o = negcnt; keep_o = '1; end
         OP_SEXTB: begin keep_o = lowmask((CW+1)'(8));
                         fidx_o = CW'(7); ffn_o = FILL_PASS; end
         OP_SEXTH: begin keep_o = lowmask((CW+1)'(XLEN/2));
                         fidx_o = CW'(XLEN/2-1); ffn_o = FILL_PASS; end
         OP_ZEXTH: begin keep_o = lowmask((CW+1)'(XLEN/2)); end
         OP_EXTU:  begin rotl_o = negcnt; keep_o = lowmask(widx); end
         OP_EXTS:  begin rotl_o = negcnt; keep_o = lowmask(widx);
                         fidx_o = top_idx; ffn_o = FILL_PASS; end
         OP_BSET:  begin keep_o = ~bit_hot; ffn_o = FILL_ONE; end
         OP_BCLR:  begin keep_o = ~bit_hot; ffn_o = FILL_ZERO; end
         OP_BINV:  begin keep_o = ~bit_hot; fidx_o = cnt_i; ffn_o = FILL_INV; end
         OP_BEXT:  begin rotl_o = negcnt; keep_o = XLEN'(1); end
         default:  begin keep_o = '0; ffn_o = FILL_ZERO; end
      endcase
   end

   // R1, R2: a shift never keeps more than XLEN bits, and a count of zero keeps them all
   always_comb begin
      if ((op_i == OP_SLL || op_i == OP_SRL) && cnt_i == '0)
         p_zero_shift_keeps_all_r1: assert (keep_o == '1);
   end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
   import bfx_pkg::*;
#(
   parameter int HALF = 16,
   localparam int XLEN = 2*HALF,
   localparam int CW   = $clog2(XLEN),
   localparam int NW   = $clog2(HALF)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      op_i,
   input  logic [XLEN-1:0] opa_i,
   input  logic [CW-1:0]   cnt_i,
   input  logic [CW-1:0]   wid_i,
   output logic [XLEN-1:0] res_o
);
   generate
      if (HALF < 8 || (HALF & (HALF-1)) != 0) begin : g_bad_half
         $error("bfx_unit: HALF must be a power of two of at least 8");
      end
   endgenerate

   logic [CW-1:0]   rotl;
   logic [XLEN-1:0] keep;
   logic [CW-1:0]   fidx;
   fill_e           ffn;

   bfx_ctrl #(.XLEN(XLEN)) u_ctrl (
      .op_i  (op_i),
      .cnt_i (cnt_i),
      .wid_i (wid_i),
      .rotl_o(rotl),
      .keep_o(keep),
      .fidx_o(fidx),
      .ffn_o (ffn)
   );

   // two half-width multiply lanes
   logic [2*HALF-1:0] prod [2];
   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         bfx_halfmul #(.HALF(HALF)) u_mul (
            .d_i(opa_i[g*HALF +: HALF]),
            .n_i(rotl[NW-1:0]),
            .p_o(prod[g])
         );
      end
   endgenerate

   // fold the products into a rotate by rotl[NW-1:0]; the half-swapped copy adds HALF
   logic [XLEN-1:0] rot_a;
   logic [XLEN-1:0] rot_b;
   logic            use_b;
   always_comb begin
      rot_a = {prod[1][HALF-1:0] | prod[0][2*HALF-1:HALF],
               prod[0][HALF-1:0] | prod[1][2*HALF-1:HALF]};
      rot_b = {rot_a[HALF-1:0], rot_a[XLEN-1:HALF]};
      use_b = rotl[CW-1];
   end

   // fill bit: select then zero/one/pass/invert, in parallel with the lanes
   logic src_bit;
   logic fill_bit;
   always_comb begin
      src_bit = opa_i[fidx];
      case (ffn)
         FILL_ZERO: fill_bit = 1'b0;
         FILL_ONE:  fill_bit = 1'b1;
         FILL_PASS: fill_bit = src_bit;
         default:   fill_bit = ~src_bit;
      endcase
   end

   logic [XLEN-1:0] res_d;
   generate
      for (genvar i = 0; i < XLEN; i++) begin : g_bit
         always_comb begin
            if (!keep[i])   res_d[i] = fill_bit;
            else if (use_b) res_d[i] = rot_b[i];
            else            res_d[i] = rot_a[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_o <= '0;
      else        res_o <= res_d;
   end

   // set once an input has really been captured after reset
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   p_sll_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(op_i) == OP_SLL |->
         (res_o & ~({XLEN{1'b1}} << $past(cnt_i))) == '0);

   p_srl_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(op_i) == OP_SRL |->
         (res_o & ~({XLEN{1'b1}} >> $past(cnt_i))) == '0);

   p_rot_keeps_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
      primed && ($past(op_i) == OP_ROL || $past(op_i) == OP_ROR) |->
         $countones(res_o) == $countones($past(opa_i)));

   p_bset_bit_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(op_i) == OP_BSET |-> res_o[$past(cnt_i)] == 1'b1);

   p_bext_single_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(op_i) == OP_BEXT |-> $onehot0(res_o) && res_o[XLEN-1:1] == '0);

   p_unused_op_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(op_i) > 4'd13 |-> res_o == '0);
endmodule

// File: tb/tb_bfx_unit.sv
module tb_bfx_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = '0;
   logic [31:0] opa_i = '0;
   logic [4:0]  cnt_i = '0;
   logic [4:0]  wid_i = '0;
   logic [31:0] res_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bfx_unit dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i),
      .cnt_i(cnt_i), .wid_i(wid_i), .res_o(res_o)
   );

   function automatic logic [31:0] rotr(input logic [31:0] a, input int s);
      logic [63:0] d;
      d = {a, a} >> (s % 32);
      return d[31:0];
   endfunction

   function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                         input int c, input int w);
      logic [31:0] r;
      logic [31:0] m;
      r = rotr(a, c);
      m = (w == 31) ? 32'hFFFF_FFFF : ((32'd1 << (w + 1)) - 32'd1);
      case (op)
         4'd0:  return a << c;
         4'd1:  return a >> c;
         4'd2:  return 32'($signed(a) >>> c);
         4'd3:  return rotr(a, (32 - c) % 32);
         4'd4:  return r;
         4'd5:  return {{24{a[7]}}, a[7:0]};
         4'd6:  return {{16{a[15]}}, a[15:0]};
         4'd7:  return {16'h0, a[15:0]};
         4'd8:  return r & m;
         4'd9:  return (r & m) | ({32{r[w]}} & ~m);
         4'd10: return a | (32'd1 << c);
         4'd11: return a & ~(32'd1 << c);
         4'd12: return a ^ (32'd1 << c);
         4'd13: return {31'h0, a[c]};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2: return "R3";
         4'd3, 4'd4: return "R4";
         4'd5, 4'd6, 4'd7: return "R5";
         4'd8: return "R6";
         4'd9: return "R7";
         4'd10, 4'd11, 4'd12: return "R8";
         4'd13: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // drive on a falling edge, captured on the next rising edge, read on the falling edge after
   task automatic run(input logic [3:0] op, input logic [31:0] a, input int c, input int w);
      @(negedge clk);
      op_i = op; opa_i = a; cnt_i = 5'(c); wid_i = 5'(w);
      @(negedge clk);
      check(req_of(op), res_o, model(op, a, c, w));
   endtask

   initial begin
      void'($urandom(32'd1234));
      op_i = 4'd3; opa_i = 32'hDEAD_BEEF; cnt_i = 5'd7;
      repeat (3) @(negedge clk);
      check("R10 reset", res_o, 32'h0);
      rst_n = 1'b1;

      // directed corners
      run(4'd0, 32'hFFFF_FFFF, 31, 0);   // R1
      run(4'd1, 32'hFFFF_FFFF, 31, 0);   // R2
      run(4'd2, 32'h8000_0000, 31, 0);   // R3
      run(4'd2, 32'h7FFF_FFFF, 16, 0);   // R3
      run(4'd3, 32'h8000_0001, 1, 0);    // R4
      run(4'd4, 32'h8000_0001, 16, 0);   // R4
      run(4'd5, 32'h1234_5680, 9, 3);    // R5 count and width ignored
      run(4'd6, 32'h0000_8001, 30, 30);  // R5
      run(4'd7, 32'hFFFF_FFFF, 5, 5);    // R5
      run(4'd8, 32'hABCD_1234, 28, 7);   // R6 wrapping field
      run(4'd9, 32'h0000_0F00, 8, 3);    // R7
      run(4'd9, 32'h1234_5678, 0, 31);   // R7 full width
      run(4'd10, 32'h0, 31, 0);          // R8
      run(4'd11, 32'hFFFF_FFFF, 0, 0);   // R8
      run(4'd12, 32'h5555_5555, 17, 0);  // R8
      run(4'd13, 32'h8000_0000, 31, 0);  // R9
      run(4'd14, 32'hFFFF_FFFF, 3, 3);   // R11
      run(4'd15, 32'hFFFF_FFFF, 0, 0);   // R11

      // R10: the result of one operation appears on the edge after it is presented
      @(negedge clk);
      op_i = 4'd10; opa_i = 32'h0; cnt_i = 5'd4; wid_i = 5'd0;
      @(posedge clk); #1;
      check("R10 latency", res_o, 32'h0000_0010);

      // every operation, every count, random operands and widths
      for (int op = 0; op < 16; op++) begin
         for (int c = 0; c < 32; c++) begin
            for (int k = 0; k < 3; k++) begin
               run(4'(op), $urandom, c, int'($urandom % 32));
            end
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule